// File: doc/BRIEF.md
# Sparse Row Update Controller for Block-Organised Configuration Memory

This controller applies sparse updates to a configuration memory whose frames are grouped eight to a block. A byte stream arrives on an 8-bit valid/ready port. It carries a block address, a block count and then, for every row of every block, a lane mask followed by the replacement bytes. A row is the eight bytes found at the same offset in the eight frames of one block. The controller first reads that row into an 8-byte holding register. It then overwrites only the lanes marked in the mask and writes the whole row back in one cycle. Rows whose mask is zero need no data bytes and cause no write.

Runs of consecutive blocks are handled in one session. The controller walks the rows of a block in order, moves on to the next block, and raises a completion flag after the last row of the last block. A behavioural model of the row-organised frame memory is part of the project. It has a fixed preset pattern so that the results of an update can be checked.

Top module: `sparse_row_update_ctrl`

## Requirements
- R1: After reset the input port is ready, done_o is low, and neither mem_rd_o nor mem_wr_o is asserted.
- R2: The first accepted byte of a session is the start block, and the second is the block count. A count of zero sets done_o with no memory access.
- R3: Each row starts with one mem_rd_o cycle followed by one capture cycle. in_ready_o is low in both, and mem_rd_o and mem_wr_o are never high together.
- R4: The vector byte accepted after the capture marks lanes: bit j selects lane j, which is frame j of the block and bits 8j+7..8j of the row word. Exactly as many data bytes as there are set bits are then taken.
- R5: Data bytes go to the selected lanes from the highest set bit down to the lowest. With mask 0x81, the first byte lands in lane 7 and the second in lane 0.
- R6: Lanes not selected keep the value read from memory.
- R7: The cycle after the last data byte is accepted, the row is written back in a single mem_wr_o cycle. The write uses the address that was read, and in_ready_o is low during it.
- R8: A zero vector byte consumes no data bytes and produces no write for that row.
- R9: Rows are visited in order 0 to ROWS-1 within a block, and blocks in ascending order from the start block. The memory word address is block*ROWS+row, so successive reads of a session use consecutive addresses.
- R10: done_o rises after the last row of the last block. It stays high with no memory activity until the next header byte is accepted, and clears one cycle after that.
- R11: The memory model presets byte lane j of word w to the low 8 bits of (8w+j) XOR 0xA5. It returns read data one cycle after mem_rd_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Input byte valid |
| in_data_i | input | 8 | Header, vector or data byte |
| in_ready_o | output | 1 | Controller can accept a byte |
| mem_rd_o | output | 1 | Row read request |
| mem_wr_o | output | 1 | Row write-back strobe |
| mem_addr_o | output | ADDR_W | Row word address, block*ROWS+row |
| mem_wdata_o | output | 64 | Row written back |
| mem_rdata_i | input | 64 | Row returned by memory, one cycle after read |
| done_o | output | 1 | Session complete |

## Verification
On every cycle, the assertions check the port-level rules. These include the handshake blocking during read, capture and write-back, the exclusion of reads against writes, the write following an accepted byte at an unchanged address, and the quiet and self-clearing behaviour of the completion flag. Some behaviour can only be shown by scenarios whose expected memory image the bench builds itself. These are lane selection, descending lane order, preservation of unselected lanes, the skipped write on zero masks, the address walk across block boundaries and the zero-count session. The scenarios include dense, empty and mixed masks and runs that reach the last block.

// File: rtl/pfu_pkg.sv
package pfu_pkg;
  localparam int unsigned PORT_W = 8;
  localparam int unsigned LANES  = PORT_W;
  localparam int unsigned ROW_W  = LANES * 8;

  typedef enum logic [2:0] {
    ST_HDR_BLK,
    ST_HDR_CNT,
    ST_RD,
    ST_CAP,
    ST_VEC,
    ST_DATA,
    ST_WR
  } pfu_state_e;
endpackage

// File: rtl/pfu_lane_iter.sv
// Walks set bits of a lane mask from the top lane downwards.
module pfu_lane_iter #(
  parameter int unsigned LANES = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [LANES-1:0] mask_i,
  input  logic             step_i,
  output logic [LANES-1:0] sel_o,
  output logic             last_o
);
  logic [LANES-1:0] pend_q;
  logic [LANES-1:0] rest;
  logic             found;

  always_comb begin
    sel_o = '0;
    found = 1'b0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (pend_q[i] && !found) begin
        sel_o[i] = 1'b1;
        found    = 1'b1;
      end
    end
    rest   = pend_q & ~sel_o;
    last_o = (rest == '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_q <= '0;
    else if (load_i) pend_q <= mask_i;
    else if (step_i) pend_q <= rest;
  end
endmodule

// File: rtl/pfu_row_buf.sv
// Eight-lane holding register: whole-row capture, single-lane byte replace.
module pfu_row_buf #(
  parameter int unsigned LANES = 8,
  localparam int unsigned ROW_W = LANES * 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_i,
  input  logic [ROW_W-1:0] cap_row_i,
  input  logic             put_i,
  input  logic [LANES-1:0] put_sel_i,
  input  logic [7:0]       put_byte_i,
  output logic [ROW_W-1:0] row_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                     q <= '0;
      else if (cap_i)                  q <= cap_row_i[g*8 +: 8];
      else if (put_i && put_sel_i[g])  q <= put_byte_i;
    end
    assign row_o[g*8 +: 8] = q;
  end
endmodule

// File: rtl/pfu_walker.sv
// Block/row position and remaining block count for one session.
module pfu_walker #(
  parameter int unsigned NUM_BLOCKS = 4,
  parameter int unsigned ROWS       = 56,
  parameter int unsigned ADDR_W     = $clog2(NUM_BLOCKS * ROWS),
  localparam int unsigned RW        = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_blk_i,
  input  logic              load_cnt_i,
  input  logic [7:0]        val_i,
  input  logic              adv_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);
  logic [RW-1:0] row_q;
  logic [7:0]    blk_q;
  logic [7:0]    cnt_q;
  logic          row_end;

  assign row_end = (row_q == RW'(ROWS - 1));
  assign last_o  = row_end && (cnt_q == 8'd1);
  assign addr_o  = ADDR_W'(blk_q) * ADDR_W'(ROWS) + ADDR_W'(row_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q <= '0;
      blk_q <= '0;
      cnt_q <= '0;
    end else begin
      if (load_blk_i) begin
        blk_q <= val_i;
        row_q <= '0;
      end
      if (load_cnt_i) cnt_q <= val_i;
      if (adv_i) begin
        if (row_end) begin
          row_q <= '0;
          blk_q <= blk_q + 8'd1;
          cnt_q <= cnt_q - 8'd1;
        end else begin
          row_q <= row_q + RW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/frame_mem.sv
// Behavioural row-organised frame memory with a preset pattern.
module frame_mem #(
  parameter int unsigned NUM_BLOCKS = 4,
  parameter int unsigned ROWS       = 56,
  parameter int unsigned ADDR_W     = $clog2(NUM_BLOCKS * ROWS),
  localparam int unsigned DEPTH     = NUM_BLOCKS * ROWS,
  localparam int unsigned ROW_W     = pfu_pkg::ROW_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ROW_W-1:0]  wdata_i,
  output logic [ROW_W-1:0]  rdata_o
);
  logic [ROW_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < DEPTH; w++)
        for (int j = 0; j < pfu_pkg::LANES; j++)
          mem_q[w][j*8 +: 8] <= 8'(w * 8 + j) ^ 8'hA5;
      rdata_o <= '0;
    end else begin
      if (rd_i) rdata_o <= mem_q[addr_i];
      if (wr_i) mem_q[addr_i] <= wdata_i;
    end
  end
endmodule

// File: rtl/sparse_row_update_ctrl.sv
module sparse_row_update_ctrl #(
  parameter int unsigned NUM_BLOCKS = 4,
  parameter int unsigned ROWS       = 56,
  localparam int unsigned ADDR_W    = $clog2(NUM_BLOCKS * ROWS),
  localparam int unsigned ROW_W     = pfu_pkg::ROW_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [7:0]        in_data_i,
  output logic              in_ready_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [ROW_W-1:0]  mem_wdata_o,
  input  logic [ROW_W-1:0]  mem_rdata_i,
  output logic              done_o
);
  import pfu_pkg::*;

  pfu_state_e       state_q, state_d;
  logic             fire;
  logic             load_blk, load_cnt, adv, walk_last;
  logic             it_load, it_step, it_last;
  logic [LANES-1:0] it_sel;
  logic             cap, put;
  logic             done_q, set_done, clr_done;

  assign in_ready_o = (state_q == ST_HDR_BLK) || (state_q == ST_HDR_CNT) ||
                      (state_q == ST_VEC)     || (state_q == ST_DATA);
  assign fire       = in_valid_i && in_ready_o;
  assign mem_rd_o   = (state_q == ST_RD);
  assign mem_wr_o   = (state_q == ST_WR);
  assign done_o     = done_q;

  always_comb begin
    state_d  = state_q;
    load_blk = 1'b0;
    load_cnt = 1'b0;
    adv      = 1'b0;
    it_load  = 1'b0;
    it_step  = 1'b0;
    cap      = 1'b0;
    put      = 1'b0;
    set_done = 1'b0;
    clr_done = 1'b0;
    unique case (state_q)
      ST_HDR_BLK: if (fire) begin
        load_blk = 1'b1;
        clr_done = 1'b1;
        state_d  = ST_HDR_CNT;
      end
      ST_HDR_CNT: if (fire) begin
        if (in_data_i == 8'd0) begin
          set_done = 1'b1;
          state_d  = ST_HDR_BLK;
        end else begin
          load_cnt = 1'b1;
          state_d  = ST_RD;
        end
      end
      ST_RD:  state_d = ST_CAP;
      ST_CAP: begin
        cap     = 1'b1;
        state_d = ST_VEC;
      end
      ST_VEC: if (fire) begin
        if (in_data_i == 8'd0) begin
          adv = 1'b1;
          if (walk_last) begin
            set_done = 1'b1;
            state_d  = ST_HDR_BLK;
          end else begin
            state_d = ST_RD;
          end
        end else begin
          it_load = 1'b1;
          state_d = ST_DATA;
        end
      end
      ST_DATA: if (fire) begin
        put     = 1'b1;
        it_step = 1'b1;
        if (it_last) state_d = ST_WR;
      end
      ST_WR: begin
        adv = 1'b1;
        if (walk_last) begin
          set_done = 1'b1;
          state_d  = ST_HDR_BLK;
        end else begin
          state_d = ST_RD;
        end
      end
      default: state_d = ST_HDR_BLK;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HDR_BLK;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (set_done)      done_q <= 1'b1;
      else if (clr_done) done_q <= 1'b0;
    end
  end

  pfu_walker #(
    .NUM_BLOCKS(NUM_BLOCKS),
    .ROWS      (ROWS),
    .ADDR_W    (ADDR_W)
  ) u_walker (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_blk_i(load_blk),
    .load_cnt_i(load_cnt),
    .val_i     (in_data_i),
    .adv_i     (adv),
    .addr_o    (mem_addr_o),
    .last_o    (walk_last)
  );

  pfu_lane_iter #(.LANES(LANES)) u_iter (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(it_load),
    .mask_i(in_data_i),
    .step_i(it_step),
    .sel_o (it_sel),
    .last_o(it_last)
  );

  pfu_row_buf #(.LANES(LANES)) u_row (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cap_i     (cap),
    .cap_row_i (mem_rdata_i),
    .put_i     (put),
    .put_sel_i (it_sel),
    .put_byte_i(in_data_i),
    .row_o     (mem_wdata_o)
  );
endmodule

// File: rtl/pfu_ctrl_chk.sv
module pfu_ctrl_chk #(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic              mem_rd_o,
  input logic              mem_wr_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              done_o
);
  p_mem_blocks_port_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o || mem_wr_o) |-> !in_ready_o);

  p_rd_wr_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o));

  p_capture_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> (!in_ready_o && !mem_rd_o && !mem_wr_o));

  // R7: write-back follows an accepted byte, at the row address already held
  p_wr_after_byte_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |-> $past(in_valid_i && in_ready_o));

  p_wr_addr_held_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |-> $stable(mem_addr_o));

  p_done_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!mem_rd_o && !mem_wr_o));

  p_done_clears_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && in_valid_i && in_ready_o) |=> !done_o);
endmodule

bind sparse_row_update_ctrl pfu_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .in_valid_i(in_valid_i),
  .in_ready_o(in_ready_o),
  .mem_rd_o  (mem_rd_o),
  .mem_wr_o  (mem_wr_o),
  .mem_addr_o(mem_addr_o),
  .done_o    (done_o)
);

// File: tb/sparse_row_update_ctrl_tb.sv
module sparse_row_update_ctrl_tb;
  localparam int NB    = 4;
  localparam int ROWS  = 56;
  localparam int DEPTH = NB * ROWS;
  localparam int AW    = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [7:0]    in_data = '0;
  logic          in_ready, mem_rd, mem_wr, done;
  logic [AW-1:0] mem_addr;
  logic [63:0]   mem_wdata, mem_rdata;

  always #10 clk = ~clk;

  sparse_row_update_ctrl #(.NUM_BLOCKS(NB), .ROWS(ROWS)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_data_i(in_data),
    .in_ready_o(in_ready), .mem_rd_o(mem_rd), .mem_wr_o(mem_wr),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .done_o(done)
  );

  frame_mem #(.NUM_BLOCKS(NB), .ROWS(ROWS)) u_mem (
    .clk_i(clk), .rst_ni(rst_n), .rd_i(mem_rd), .wr_i(mem_wr),
    .addr_i(mem_addr), .wdata_i(mem_wdata), .rdata_o(mem_rdata)
  );

  int errors = 0;
  int checks = 0;
  logic [63:0] exp_mem [DEPTH];
  logic [63:0] sh_mem  [DEPTH];
  int exp_base, rd_cnt, wr_cnt, rd_bad, wr_bad, rdy_bad;
  logic [AW-1:0] last_rd;

  function automatic logic [7:0] preset_byte(int w, int j);
    return 8'(w * 8 + j) ^ 8'hA5; // R11
  endfunction

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Port monitor, sampled mid-cycle
  always @(negedge clk) begin
    if (rst_n) begin
      if ((mem_rd || mem_wr) && in_ready) rdy_bad++;
      if (mem_rd) begin
        if (mem_addr != AW'(exp_base + rd_cnt)) rd_bad++;
        last_rd = mem_addr;
        rd_cnt++;
      end
      if (mem_wr) begin
        if (mem_addr != last_rd) wr_bad++;
        sh_mem[mem_addr] = mem_wdata;
        wr_cnt++;
      end
    end
  end

  task automatic send(input logic [7:0] b);
    if ($urandom_range(3) == 0) @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_done();
    for (int t = 0; t < 200 && !done; t++) @(negedge clk);
  endtask

  // mode 0: random, 1: directed order/dense rows, zero_pct sets empty-mask share
  task automatic run(int start, int cnt, int zero_pct, int mode);
    int exp_wr = 0;
    int mism = 0;
    int w0 = start * ROWS;
    rd_cnt = 0; wr_cnt = 0; rd_bad = 0; wr_bad = 0; rdy_bad = 0;
    exp_base = start * ROWS;
    send(8'(start));
    chk("R10", "done cleared after header byte", {63'd0, done}, 64'd0);
    send(8'(cnt));
    for (int b = 0; b < cnt; b++) begin
      for (int r = 0; r < ROWS; r++) begin
        int w = (start + b) * ROWS + r;
        logic [7:0] vec;
        if (mode == 1 && w == w0)          vec = 8'h81;
        else if (mode == 1 && w == w0 + 1) vec = 8'hFF;
        else if (int'($urandom_range(99)) < zero_pct) vec = 8'h00;
        else vec = 8'($urandom);
        send(vec);
        if (vec != 0) exp_wr++;
        for (int j = 7; j >= 0; j--) begin
          if (vec[j]) begin
            logic [7:0] d;
            if (mode == 1 && w == w0) d = (j == 7) ? 8'h11 : 8'h22;
            else d = 8'($urandom);
            send(d);
            exp_mem[w][j*8 +: 8] = d;
          end
        end
      end
    end
    wait_done();
    chk("R10", "done after last row", {63'd0, done}, 64'd1);
    chk("R3", "one read per row", 64'(rd_cnt), 64'(cnt * ROWS));
    chk("R9", "read address walk", 64'(rd_bad), 64'd0);
    chk("R7", "write address equals read address", 64'(wr_bad), 64'd0);
    chk("R8", "writes only for nonzero masks", 64'(wr_cnt), 64'(exp_wr));
    chk("R3", "port blocked during memory cycles", 64'(rdy_bad), 64'd0);
    for (int w = 0; w < DEPTH; w++) if (sh_mem[w] !== exp_mem[w]) mism++;
    chk("R6", "memory image vs expected (R4 lanes)", 64'(mism), 64'd0);
    if (mode == 1) begin
      chk("R5", "first byte to lane 7", 64'(sh_mem[w0][63:56]), 64'h11);
      chk("R5", "second byte to lane 0", 64'(sh_mem[w0][7:0]), 64'h22);
      chk("R6", "middle lanes kept", sh_mem[w0][55:8],
          {preset_byte(w0,6), preset_byte(w0,5), preset_byte(w0,4),
           preset_byte(w0,3), preset_byte(w0,2), preset_byte(w0,1)});
    end
    repeat (5) @(negedge clk);
    chk("R10", "done held while idle", {63'd0, done}, 64'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int w = 0; w < DEPTH; w++)
      for (int j = 0; j < 8; j++) begin
        exp_mem[w][j*8 +: 8] = preset_byte(w, j);
        sh_mem[w][j*8 +: 8]  = preset_byte(w, j);
      end
    exp_base = 0; rd_cnt = 0; wr_cnt = 0; rd_bad = 0; wr_bad = 0; rdy_bad = 0;
    last_rd = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "ready after reset", {63'd0, in_ready}, 64'd1);
    chk("R1", "done low after reset", {63'd0, done}, 64'd0);
    chk("R1", "no memory access after reset", {62'd0, mem_rd, mem_wr}, 64'd0);

    run(0, 1, 20, 1);
    run(1, 3, 30, 0);
    run(3, 1, 100, 0);

    rd_cnt = 0; wr_cnt = 0;
    send(8'd2);
    send(8'd0);
    wait_done();
    chk("R2", "zero count sets done", {63'd0, done}, 64'd1);
    chk("R2", "zero count makes no access", 64'(rd_cnt + wr_cnt), 64'd0);

    run(0, 4, 50, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule